// File: doc/BRIEF.md
# Multi-Board Pixel Sample Collator and Byte Packer

This block gathers one pixel position's worth of digitized samples from several back-end boards, each of which presents all of its channels as parallel 18-bit words, and turns them into one framed byte stream for a fast serial link. When the pixel strobe arrives and the block is idle, it takes a snapshot of every board's words in one clock. It then drains that snapshot as a packet. The packet opens with a two-byte pixel counter. The samples follow in a fixed board-then-channel order, packed with no padding so that every four samples occupy nine bytes.

The output is a plain valid/ready byte stream that carries start and end markers. A strobe that arrives while a packet is still draining cannot be stored. That pixel is dropped, and a sticky overflow flag is raised.

Top module: `pixel_collator`

## Requirements
- R1: After reset, `out_valid`, `out_sop`, `out_eop` and `overflow` are all 0.
- R2: Within a packet, samples leave in the order board 0 channel 0 through channel 23, then board 1, and so on to board 5. Board b channel c is taken from `brd_data[(b*24+c)*18 +: 18]`.
- R3: Samples are packed MSB first into a continuous bit stream with no padding, so every four samples form nine bytes and the 144 samples of one pixel give exactly 324 data bytes.
- R4: Each packet begins with two header bytes holding a 16-bit pixel counter, high byte first. `out_sop` is 1 only on the first header byte.
- R5: Each packet is 326 bytes long. `out_eop` is 1 only on the last data byte.
- R6: A `pix_strobe` that arrives while a packet is being sent drops that pixel and sets `overflow`. The flag then stays at 1 until reset, and the packet in progress goes on unchanged.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_sop` and `out_eop` hold their values. No byte is lost or reordered under back-pressure.
- R8: A board whose `brd_valid` bit is 0 at the accepting strobe contributes 24 zero samples.
- R9: The pixel counter starts at 0 after reset and advances by one per packet sent. Dropped pixels do not advance it.
- R10: A strobe accepted while idle raises `out_valid` together with `out_sop` on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_strobe | input | 1 | Pixel position ready; capture all boards |
| brd_valid | input | 6 | Per-board word-set valid flag |
| brd_data | input | 2592 | All boards' 18-bit words, flattened |
| out_ready | input | 1 | Downstream accepts a byte |
| out_data | output | 8 | Stream byte |
| out_valid | output | 1 | Stream byte present |
| out_sop | output | 1 | First byte of packet |
| out_eop | output | 1 | Last byte of packet |
| overflow | output | 1 | Sticky: a pixel was dropped |

## Verification
The bench builds the block with its default parameters: six boards, 24 channels and 18-bit samples. This yields full 326-byte packets, in which the sample-to-byte boundary cycles through all four of its alignments 36 times. With these values, every byte straddle is exercised, including the final byte that ends exactly on the last sample. The bench also reaches the mid-packet strobe drop and packets in which some boards are marked invalid.

// File: rtl/pixel_collator.sv
module pixel_collator #(
  parameter int NBRD = 6,
  parameter int NCH  = 24,
  parameter int W    = 18,
  parameter int CW   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pix_strobe,
  input  logic [NBRD-1:0]       brd_valid,
  input  logic [NBRD*NCH*W-1:0] brd_data,
  input  logic                  out_ready,
  output logic [7:0]            out_data,
  output logic                  out_valid,
  output logic                  out_sop,
  output logic                  out_eop,
  output logic                  overflow
);
  localparam int NS     = NBRD * NCH;
  localparam int NBYTES = (NS * W + 7) / 8;
  localparam int HB     = CW / 8;
  localparam int LAST   = HB + NBYTES - 1;
  localparam int IW     = $clog2(LAST + 1);
  localparam int SW     = $clog2(NS);
  localparam int OW     = $clog2(W) + 1;

  logic [W-1:0]    smp [NS];
  logic            busy;
  logic [IW-1:0]   idx;
  logic [SW-1:0]   s, sn;
  logic [OW-1:0]   off, noff;
  logic [CW-1:0]   cnt, hsh;
  logic [2*W-1:0]  win, sh;
  logic            accept, fire, last;

  assign accept = pix_strobe && !busy;
  assign fire   = busy && out_ready;
  assign last   = (idx == IW'(LAST));

  assign sn   = (s == SW'(NS - 1)) ? s : s + 1'b1;
  assign win  = {smp[s], smp[sn]};
  assign sh   = win << off;
  assign hsh  = cnt << {idx, 3'b000};
  assign noff = off + OW'(8);

  assign out_valid = busy;
  assign out_sop   = busy && (idx == '0);
  assign out_eop   = busy && last;
  assign out_data  = (idx < IW'(HB)) ? hsh[CW-1 -: 8] : sh[2*W-1 -: 8];

  always_ff @(posedge clk) begin
    if (accept)
      for (int i = 0; i < NS; i++)
        smp[i] <= brd_valid[i / NCH] ? brd_data[i*W +: W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx      <= '0;
      s        <= '0;
      off      <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      if (pix_strobe && busy) overflow <= 1'b1;
      if (accept) begin
        busy <= 1'b1;
        idx  <= '0;
        s    <= '0;
        off  <= '0;
      end else if (fire) begin
        if (last) begin
          busy <= 1'b0;
          cnt  <= cnt + 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
        if (idx >= IW'(HB)) begin
          if (noff >= OW'(W)) begin
            off <= noff - OW'(W);
            s   <= s + 1'b1;
          end else begin
            off <= noff;
          end
        end
      end
    end
  end
endmodule

module pixel_collator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_strobe,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_sop,
  input logic       out_eop,
  input logic       overflow
);
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_sop && !out_eop));
  p_sop_eop_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_sop && out_eop));
  p_drop_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_strobe && out_valid) |=> overflow);
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));
  p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_strobe && !out_valid) |=> (out_valid && out_sop));
endmodule

bind pixel_collator pixel_collator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pix_strobe(pix_strobe), .out_ready(out_ready),
  .out_data(out_data), .out_valid(out_valid), .out_sop(out_sop),
  .out_eop(out_eop), .overflow(overflow)
);

// File: tb/tb_pixel_collator.sv
module tb_pixel_collator;
  localparam int NB = 6, NC = 24, W = 18, NS = NB * NC, PLEN = 326;

  logic clk = 0, rst_n = 0, pix_strobe = 0, out_ready = 0;
  logic [NB-1:0] brd_valid = '0;
  logic [NB*NC*W-1:0] brd_data = '0;
  logic [7:0] out_data;
  logic out_valid, out_sop, out_eop, overflow;
  int checks = 0, failures = 0, cyc = 0;
  logic [15:0] exp_cnt = 0;

  always #2 clk = ~clk;

  pixel_collator dut (.clk(clk), .rst_n(rst_n), .pix_strobe(pix_strobe), .brd_valid(brd_valid),
    .brd_data(brd_data), .out_ready(out_ready), .out_data(out_data), .out_valid(out_valid),
    .out_sop(out_sop), .out_eop(out_eop), .overflow(overflow));

  // {seed[15:0], board mask[5:0], ready mode[1:0]}
  localparam logic [23:0] VEC [5] = '{
    {16'h1234, 6'b111111, 2'd0}, {16'hBEEF, 6'b111111, 2'd1},
    {16'h0F0F, 6'b101101, 2'd2}, {16'h7A55, 6'b000001, 2'd3},
    {16'hC3A9, 6'b111110, 2'd1}};

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] samp(input logic [15:0] seed, input logic [5:0] mask, input int i);
    logic [31:0] v;
    if (!mask[i / NC]) return '0;
    v = {16'h0, seed} * 32'd40503 + i * 32'd2654435 + (i << 13);
    return v[17:0] ^ v[31:14];
  endfunction

  function automatic logic [7:0] exp_byte(input logic [15:0] seed, input logic [5:0] mask, input int k);
    logic [7:0] b;
    for (int j = 0; j < 8; j++) begin
      int p = 8 * k + j;
      logic [17:0] sv = samp(seed, mask, p / W);
      b[7 - j] = sv[17 - (p % W)];
    end
    return b;
  endfunction

  function automatic bit rdy(input logic [1:0] mode, input int c);
    case (mode)
      2'd0: return 1'b1;
      2'd1: return c[0];
      2'd2: return (c % 3) == 0;
      default: return ((c * 7) % 5) > 1;
    endcase
  endfunction

  task automatic send(input logic [15:0] seed, input logic [5:0] mask, input logic [1:0] mode, input bit inject);
    int nb = 0, bad = 0, c = 0;
    bit stall = 0, done = 0, injected = 0;
    logic [7:0] hold;
    for (int i = 0; i < NS; i++) brd_data[i*W +: W] = samp(seed, '1, i);
    brd_valid = mask;
    @(negedge clk); pix_strobe = 1; out_ready = 0;
    @(negedge clk); pix_strobe = 0;
    chk(out_valid && out_sop, "R10 start", {out_valid, out_sop}, 3);
    brd_data = '0; brd_valid = '0;
    while (!done && c < 2000) begin
      if (c > 0) @(negedge clk);
      pix_strobe = inject && nb == 100 && !injected;
      if (pix_strobe) injected = 1;
      if (stall && out_data !== hold) bad++;
      out_ready = rdy(mode, c);
      c++;
      #1;
      stall = out_valid && !out_ready;
      hold = out_data;
      if (out_valid && out_ready) begin
        logic [7:0] e;
        e = (nb == 0) ? exp_cnt[15:8] : (nb == 1) ? exp_cnt[7:0] : exp_byte(seed, mask, nb - 2);
        if (nb < 2 && out_data !== e) chk(0, "R4/R9 header", out_data, e);
        else if (nb >= 2 && out_data !== e) bad++;
        if (out_sop !== (nb == 0)) chk(0, "R4 sop", out_sop, nb == 0);
        if (out_eop) begin
          done = 1;
          chk(nb == PLEN - 1, "R5 eop position", nb, PLEN - 1);
        end
        nb++;
      end
    end
    chk(done, "R5 packet completes", done, 1);
    chk(bad == 0, "R2/R3/R7/R8 data bytes", bad, 0);
    exp_cnt++;
    @(negedge clk); pix_strobe = 0; out_ready = 0;
    chk(!out_valid, "R5 idle after eop", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_sop && !out_eop && !overflow, "R1 reset state",
        {out_valid, out_sop, out_eop, overflow}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!overflow, "R1 no overflow", overflow, 0);
    for (int v = 0; v < 5; v++) send(VEC[v][23:8], VEC[v][7:2], VEC[v][1:0], 0);
    chk(!overflow, "R6 no spurious overflow", overflow, 0);
    send(16'h5A5A, 6'b111111, 2'd1, 1);
    chk(overflow, "R6 overflow set", overflow, 1);
    send(16'h0001, 6'b010101, 2'd0, 0);
    chk(overflow, "R6 overflow sticky", overflow, 1);
    chk(exp_cnt == 7, "R9 counter tracking", exp_cnt, 7);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule